// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores received Ethernet frames into a circular area of a byte-wide packet memory. The memory is split into 256-byte pages. The ring spans the pages from a first page up to, but not including, an end page. The block keeps a write-position page, `cur_pg`. The host frees space by moving a boundary page forward. Frames are accepted only when the free space between `cur_pg` and the boundary leaves room for a full-size frame. Receive is also refused while the host holds the halt input.

A frame starts with a one-cycle start strobe that carries the payload length. The block then writes a four-byte header at the start of the current page. It takes the payload one byte per cycle under a valid/ready handshake. Frames shorter than the minimum are padded with zero bytes. The write address wraps from the end of the ring back to its first page. When the last byte is written, `cur_pg` moves to the page after the frame and a one-cycle done pulse serves as the receive interrupt request. The header carries the link to that next page, so software can walk the ring.

Top module: `rx_ring_writer`

## Requirements
- R1: While `cmd_stop` is high, `rx_ready` is low. A `fr_start` in that state causes no memory write and leaves `cur_pg` unchanged.
- R2: Addresses are page×256. Free space is boundary−current when current is below boundary. Otherwise it is (end−first)×256 − (current−boundary). When idle, `rx_ready` is high exactly when free space is at least 1518 bytes and `cmd_stop` is low.
- R3: The header is four bytes at addresses cur_pg×256 onward, in this order: status 0x01, next page, stored length bits 7:0, stored length bits 15:8.
- R4: The stored length is max(len,60)+4. A payload shorter than 60 bytes is followed by zero bytes until 60 payload bytes are written.
- R5: next page = cur_pg + ceil((stored length + 4)/256). If the result is at or beyond the end page, (end−first) is subtracted from it.
- R6: Each write uses an address one above the previous one. A write that would land on end×256 lands on first×256 instead. A frame makes exactly 4+max(len,60) writes.
- R7: `byte_ready` is high only in the payload phase, until `fr_len` bytes have been taken. Bytes taken under `byte_valid`&&`byte_ready` are stored in arrival order right after the header.
- R8: `rx_done` is high for exactly one cycle, the cycle after the last write of a frame. From that cycle on, `cur_pg` shows the next page.
- R9: `cur_set` loads `cur_set_pg` into `cur_pg` while idle.
- R10: After reset, `cur_pg` is 0 and `mem_we`, `rx_done` and `byte_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_stop | input | 1 | Host halt: refuse new frames |
| ring_first | input | 8 | First page of the ring |
| ring_end | input | 8 | Page after the last ring page |
| ring_bound | input | 8 | Boundary page the host has reclaimed up to |
| cur_set | input | 1 | Load current page (idle only) |
| cur_set_pg | input | 8 | Value for `cur_set` |
| fr_start | input | 1 | Frame start strobe |
| fr_len | input | 11 | Payload length with `fr_start` |
| rx_ready | output | 1 | A frame start would be accepted |
| byte_valid | input | 1 | Payload byte present |
| byte_data | input | 8 | Payload byte |
| byte_ready | output | 1 | Payload byte is taken this cycle if valid |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_pg | output | 8 | Current write page |
| rx_done | output | 1 | Frame stored (receive interrupt request) |

## Verification
The bench targets the wrap at the ring end, both in addresses and in the next-page link. A design that compared with greater-than instead of equality would run past the end page or leave the link pointing outside the ring. It also probes the free-space limit on both sides and the empty case where current equals boundary. An off-by-one there either drops frames that should fit or overwrites data the host has not read. Short and zero-length frames check padding and the stored length: a design that padded wrongly would report a length the memory does not hold. Gaps in `byte_valid` check that no byte is stored twice or skipped, and the done pulse is timed against the last write.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int PG_W      = 8;
  localparam int AW        = PG_W + 8;
  localparam int LEN_W     = 11;
  localparam int SL_W      = LEN_W + 1;
  localparam int MAX_FRAME = 1514;
  localparam int MIN_FRAME = 60;
  localparam int HDR_B     = 4;
  localparam int CRC_B     = 4;
  localparam logic [7:0] ST_GOOD = 8'h01;

  typedef logic [PG_W-1:0]        page_t;
  typedef logic [AW-1:0]          addr_t;
  typedef logic signed [AW+1:0]   room_t;
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_PAD} wr_state_e;

  // free bytes between write page and boundary page
  function automatic room_t ring_room(page_t cur, page_t bnd, page_t rfirst, page_t rend);
    room_t c, b, span;
    c    = room_t'({cur, 8'h00});
    b    = room_t'({bnd, 8'h00});
    span = room_t'({rend - rfirst, 8'h00});
    if (c < b) return b - c;
    return span - (c - b);
  endfunction

  function automatic logic [SL_W-1:0] stored_len(logic [LEN_W-1:0] len, int min_len);
    logic [SL_W-1:0] l;
    l = (int'(len) < min_len) ? SL_W'(min_len) : SL_W'(len);
    return l + SL_W'(HDR_B);
  endfunction

  function automatic page_t next_page(page_t cur, logic [SL_W-1:0] slen, page_t rfirst, page_t rend);
    logic [SL_W-1:0] span;
    logic [PG_W:0]   np;
    span = slen + SL_W'(CRC_B + 255);
    np   = {1'b0, cur} + (PG_W+1)'(span >> 8);
    if (np >= {1'b0, rend}) np = np - {1'b0, rend - rfirst};
    return np[PG_W-1:0];
  endfunction
endpackage

// File: rtl/rx_space_chk.sv
module rx_space_chk import rx_ring_pkg::*; #(
  parameter int HEADROOM = MAX_FRAME + HDR_B
) (
  input  page_t cur,
  input  page_t bnd,
  input  page_t rfirst,
  input  page_t rend,
  input  logic  halted,
  output room_t room,
  output logic  fits
);
  assign room = ring_room(cur, bnd, rfirst, rend);
  assign fits = !halted && (room >= room_t'(HEADROOM));
endmodule

// File: rtl/rx_wr_addr.sv
module rx_wr_addr import rx_ring_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t load_addr,
  input  logic  step,
  input  page_t rfirst,
  input  page_t rend,
  output addr_t addr,
  output logic  wrap_evt
);
  addr_t inc;
  assign inc      = addr + 1'b1;
  assign wrap_evt = step && (inc == {rend, 8'h00});

  always_ff @(posedge clk) begin
    if (!rst_n)      addr <= '0;
    else if (load)   addr <= load_addr;
    else if (step)   addr <= wrap_evt ? {rfirst, 8'h00} : inc;
  end

  // R6
  wrap_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !load) |=> (addr == $past({rfirst, 8'h00})));
  // R6
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap_evt && !load) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer import rx_ring_pkg::*; #(
  parameter int MIN_LEN  = MIN_FRAME,
  parameter int HEADROOM = MAX_FRAME + HDR_B,
  parameter logic [PG_W-1:0] CUR_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stop,
  input  logic [PG_W-1:0]  ring_first,
  input  logic [PG_W-1:0]  ring_end,
  input  logic [PG_W-1:0]  ring_bound,
  input  logic             cur_set,
  input  logic [PG_W-1:0]  cur_set_pg,
  input  logic             fr_start,
  input  logic [LEN_W-1:0] fr_len,
  output logic             rx_ready,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic [PG_W-1:0]  cur_pg,
  output logic             rx_done
);
  wr_state_e        st;
  logic [1:0]       hidx;
  logic [LEN_W-1:0] len_q, cnt;
  logic [SL_W-1:0]  slen_q;
  logic [15:0]      slen16;
  page_t            nxt_q, cur_q;
  logic             done_q;

  room_t room_w;
  logic  fits_w, wrap_w;
  logic  accept, take, last_hdr, pay_end, pad_end, finish, need_pad;
  logic [LEN_W-1:0] pad_min;

  rx_space_chk #(.HEADROOM(HEADROOM)) u_space (
    .cur(cur_q), .bnd(ring_bound), .rfirst(ring_first), .rend(ring_end),
    .halted(cmd_stop), .room(room_w), .fits(fits_w));

  rx_wr_addr u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_addr({cur_q, 8'h00}),
    .step(mem_we), .rfirst(ring_first), .rend(ring_end),
    .addr(mem_addr), .wrap_evt(wrap_w));

  assign pad_min    = LEN_W'(MIN_LEN);
  assign rx_ready   = (st == S_IDLE) && fits_w;
  assign accept     = (st == S_IDLE) && fr_start && fits_w;
  assign byte_ready = (st == S_DATA);
  assign take       = byte_ready && byte_valid;
  assign last_hdr   = (st == S_HDR) && (hidx == 2'd3);
  assign need_pad   = (len_q < pad_min);
  assign pay_end    = take && (cnt + 1'b1 == len_q);
  assign pad_end    = (st == S_PAD) && (cnt + 1'b1 == pad_min);
  assign finish     = (pay_end && !need_pad) || pad_end;
  assign mem_we     = (st == S_HDR) || take || (st == S_PAD);
  assign slen16     = 16'(slen_q);
  assign cur_pg     = cur_q;
  assign rx_done    = done_q;

  always_comb begin
    mem_wdata = 8'h00;
    case (st)
      S_HDR: begin
        case (hidx)
          2'd0: mem_wdata = ST_GOOD;
          2'd1: mem_wdata = nxt_q;
          2'd2: mem_wdata = slen16[7:0];
          default: mem_wdata = slen16[15:8];
        endcase
      end
      S_DATA:  mem_wdata = byte_data;
      default: mem_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hidx   <= '0;
      len_q  <= '0;
      cnt    <= '0;
      slen_q <= '0;
      nxt_q  <= '0;
      cur_q  <= CUR_INIT;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      case (st)
        S_IDLE: begin
          if (accept) begin
            len_q  <= fr_len;
            slen_q <= stored_len(fr_len, MIN_LEN);
            nxt_q  <= next_page(cur_q, stored_len(fr_len, MIN_LEN), ring_first, ring_end);
            hidx   <= '0;
            cnt    <= '0;
            st     <= S_HDR;
          end else if (cur_set) begin
            cur_q <= cur_set_pg;
          end
        end
        S_HDR: begin
          hidx <= hidx + 1'b1;
          if (last_hdr) st <= (len_q == '0) ? S_PAD : S_DATA;
        end
        S_DATA: begin
          if (take) begin
            cnt <= cnt + 1'b1;
            if (pay_end) st <= need_pad ? S_PAD : S_IDLE;
          end
        end
        S_PAD: begin
          cnt <= cnt + 1'b1;
          if (pad_end) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (finish) cur_q <= nxt_q;
    end
  end

  // R1
  halt_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |-> !rx_ready);
  // R2
  ready_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (room_w >= room_t'(HEADROOM)));
  // R3
  header_at_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_we && mem_addr == {$past(cur_q), 8'h00} && mem_wdata == ST_GOOD));
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (rx_done && cur_pg == $past(nxt_q)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_stop = 1'b0;
  logic [7:0] ring_first = 8'h40, ring_end = 8'h80, ring_bound = 8'h40;
  logic cur_set = 1'b0;
  logic [7:0] cur_set_pg = 8'h00;
  logic fr_start = 1'b0;
  logic [10:0] fr_len = '0;
  logic rx_ready, byte_ready, mem_we, rx_done;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00, mem_wdata, cur_pg;
  logic [15:0] mem_addr;

  int n_vec = 0, n_bad = 0;
  int bcur = 0;

  always #5 clk = ~clk;

  rx_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .cmd_stop(cmd_stop),
    .ring_first(ring_first), .ring_end(ring_end), .ring_bound(ring_bound),
    .cur_set(cur_set), .cur_set_pg(cur_set_pg),
    .fr_start(fr_start), .fr_len(fr_len), .rx_ready(rx_ready),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_pg(cur_pg), .rx_done(rx_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int free_bytes(int cur, int bnd);
    int c = cur * 256;
    int b = bnd * 256;
    if (c < b) return b - c;
    return (int'(ring_end) - int'(ring_first)) * 256 - (c - b);
  endfunction

  function automatic bit want_ready(int cur);
    return !cmd_stop && free_bytes(cur, int'(ring_bound)) >= 1514 + 4;
  endfunction

  function automatic int link_of(int cur, int len);
    int body = (len < 60 ? 60 : len) + 4;
    int n = cur + (body + 4 + 255) / 256;
    if (n >= int'(ring_end)) n = n - (int'(ring_end) - int'(ring_first));
    return n;
  endfunction

  function automatic int after(int a);
    if (a + 1 == int'(ring_end) * 256) return int'(ring_first) * 256;
    return a + 1;
  endfunction

  task automatic set_cur(input int p);
    @(negedge clk); cur_set = 1'b1; cur_set_pg = 8'(p);
    @(negedge clk); cur_set = 1'b0;
    #1 chk(int'(cur_pg) == p, "R9 cur load", int'(cur_pg), p);
    bcur = p;
  endtask

  task automatic set_ring(input int f, input int e, input int b);
    @(negedge clk);
    ring_first = 8'(f); ring_end = 8'(e); ring_bound = 8'(b);
  endtask

  task automatic send_frame(input int len, input int gap_pct);
    logic [7:0] pl [0:2047];
    int la [0:2100];
    logic [7:0] ld [0:2100];
    int wn = 0, sent = 0, lastwe = -10, donek = -1, bad, a, plen, slen, nxt;
    bit rdy;
    for (int i = 0; i < len; i++) pl[i] = 8'($urandom);
    plen = len < 60 ? 60 : len;
    slen = plen + 4;
    nxt  = link_of(bcur, len);
    @(negedge clk);
    rdy = want_ready(bcur);
    #1 chk(rx_ready == rdy, "R2 ready vs free space", int'(rx_ready), int'(rdy));
    if (!rdy) return;
    fr_start = 1'b1; fr_len = 11'(len);
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      fr_start   = 1'b0;
      byte_valid = (sent < len) && (($urandom % 100) >= gap_pct);
      byte_data  = (sent < len) ? pl[sent] : 8'h00;
      #1;
      if (rx_done) begin donek = k; break; end
      if (mem_we) begin la[wn] = int'(mem_addr); ld[wn] = mem_wdata; wn++; lastwe = k; end
      if (byte_ready && byte_valid) sent++;
      if (wn > 2100) break;
    end
    byte_valid = 1'b0;
    chk(wn == 4 + plen, "R6 write count", wn, 4 + plen);
    chk(donek == lastwe + 1, "R8 done timing", donek, lastwe + 1);
    chk(int'(cur_pg) == nxt, "R5 next page", int'(cur_pg), nxt);
    if (wn == 4 + plen) begin
      bad = 0; a = bcur * 256;
      for (int i = 0; i < wn; i++) begin
        if (la[i] != a) bad++;
        a = after(a);
      end
      chk(bad == 0, "R6 address sequence/wrap", bad, 0);
      chk(ld[0] == 8'h01, "R3 status byte", int'(ld[0]), 1);
      chk(int'(ld[1]) == nxt, "R3 link byte", int'(ld[1]), nxt);
      chk(int'(ld[2]) == (slen & 255), "R3 length low", int'(ld[2]), slen & 255);
      chk(int'(ld[3]) == (slen >> 8), "R3 length high", int'(ld[3]), slen >> 8);
      bad = 0;
      for (int i = 0; i < len; i++) if (ld[4 + i] != pl[i]) bad++;
      chk(bad == 0, "R7 payload order", bad, 0);
      bad = 0;
      for (int i = len; i < plen; i++) if (ld[4 + i] != 8'h00) bad++;
      chk(bad == 0, "R4 zero pad", bad, 0);
    end
    @(negedge clk); #1;
    chk(rx_done == 1'b0, "R8 done single cycle", int'(rx_done), 0);
    bcur = nxt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(cur_pg == 8'h00, "R10 reset cur", int'(cur_pg), 0);
    chk(mem_we == 1'b0, "R10 reset we", int'(mem_we), 0);
    chk(rx_done == 1'b0, "R10 reset done", int'(rx_done), 0);
    chk(byte_ready == 1'b0, "R10 reset byte_ready", int'(byte_ready), 0);
    @(negedge clk); rst_n = 1'b1;

    // empty ring, short and zero-length frames
    set_ring(8'h40, 8'h80, 8'h40);
    set_cur(8'h40);
    ring_bound = 8'h40;
    send_frame(20, 30);
    ring_bound = 8'(bcur);
    send_frame(0, 0);
    ring_bound = 8'(bcur);
    send_frame(60, 0);
    ring_bound = 8'(bcur);
    send_frame(1514, 20);

    // wrap across the end page
    set_cur(8'h7E);
    ring_bound = 8'h7D;
    send_frame(600, 10);
    chk(bcur == 8'h41, "R5 wrapped link", bcur, 8'h41);

    // halt input
    @(negedge clk); cmd_stop = 1'b1; ring_bound = 8'(bcur);
    #1 chk(rx_ready == 1'b0, "R1 ready low when halted", int'(rx_ready), 0);
    @(negedge clk); fr_start = 1'b1; fr_len = 11'd100;
    @(negedge clk); fr_start = 1'b0;
    begin
      int wr = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk); #1;
        if (mem_we || byte_ready) wr++;
      end
      chk(wr == 0, "R1 no writes when halted", wr, 0);
      chk(int'(cur_pg) == bcur, "R1 cur unchanged", int'(cur_pg), bcur);
    end
    @(negedge clk); cmd_stop = 1'b0;

    // free-space threshold
    set_cur(8'h50);
    ring_bound = 8'h55;
    send_frame(100, 0);
    ring_bound = 8'h56;
    send_frame(100, 0);

    // small ring, refusal after a large frame, then wrap
    set_ring(8'h10, 8'h18, 8'h10);
    set_cur(8'h10);
    send_frame(1514, 0);
    send_frame(50, 0);
    ring_bound = 8'h17;
    send_frame(50, 0);
    ring_bound = 8'(bcur);
    send_frame(700, 25);

    // random traffic
    set_ring(8'h40, 8'h80, 8'h40);
    set_cur(8'h40);
    for (int it = 0; it < 24; it++) begin
      @(negedge clk);
      if ($urandom % 2 == 0) ring_bound = 8'(bcur);
      else ring_bound = 8'(8'h40 + $urandom % 64);
      send_frame(int'($urandom % 1515), int'($urandom % 50));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule